// File: doc/BRIEF.md
# Known-Bits Bound Sharpener

This block tightens an unsigned bound on a variable so that it agrees with what is known about the variable's individual bits. The bit knowledge arrives as two masks. The may-be-zero mask has a 1 wherever the bit is allowed to be 0. The may-be-one mask has a 1 wherever the bit is allowed to be 1. A bit that is clear in the may-be-zero mask is forced to 1. A bit that is clear in the may-be-one mask is forced to 0. The masks are assumed consistent: every bit position is set in at least one of them.

In raise mode the block returns the smallest consistent value that is not below the given bound. It finds the highest bound bit that disagrees with the masks. From that position upward it takes the lowest clear bit that may be one, sets it, keeps the bits above it, and clears the bits below it. It then forces the must-be-one bits on. One rule covers both kinds of disagreement: a bit that is too low and a bit that is too high.

In lower mode the block returns the largest consistent value that does not exceed the bound. It does this by running the raise rule on the complemented bound with the two masks exchanged, then complementing the result. When no consistent value exists on the requested side of the bound, an infeasible flag is raised and the bound comes back unchanged. The result is registered and appears one cycle after the request.

Top module: `kb_bound_sharpener`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge, and low otherwise.
- R2: While reset is asserted and directly after it, `out_valid`, `out_bound` and `out_infeasible` are all 0.
- R3: When every bound bit already agrees with the masks, the result equals the input bound with `out_infeasible` low, in both modes.
- R4: With `in_upper` = 0, the result is the smallest value v ≥ bound such that v has every must-be-one bit set and every cannot-be-one bit clear. For example, a bound of 5 with bit 0 known zero gives 6.
- R5: With `in_upper` = 1, the result is the largest such consistent value v ≤ bound.
- R6: When no consistent value exists on the requested side of the bound, `out_infeasible` is 1 and `out_bound` equals the input bound.
- R7: Whenever `out_infeasible` is 0, `out_bound` has every bit set where `in_may_zero` was 0 and every bit clear where `in_may_one` was 0.
- R8: In a cycle where `in_valid` is low, `out_bound` and `out_infeasible` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_upper | input | 1 | 0: raise a lower bound, 1: lower an upper bound |
| in_bound | input | WIDTH | Bound to sharpen |
| in_may_zero | input | WIDTH | 1 where the bit may be 0 |
| in_may_one | input | WIDTH | 1 where the bit may be 1 |
| out_valid | output | 1 | Result strobe |
| out_bound | output | WIDTH | Sharpened bound |
| out_infeasible | output | 1 | No consistent value on the requested side |

## Verification
A fault in the highest-wrong-bit encoder or in the candidate pick shows up at the ports as a result that is either not minimal (or not maximal), or that breaks the masks. The error appears one cycle after the offending request. The bench compares every result against an exhaustive search on an 8-bit instance, so such an error is caught on the first request that exercises it. A fault in the mode swap shows up only on lower-mode requests, which the bench interleaves with raise-mode requests. A fault in the hold path shows up during idle gaps.

// File: rtl/kb_pkg.sv
package kb_pkg;
    typedef enum logic {
        KB_RAISE_LOW  = 1'b0,
        KB_LOWER_HIGH = 1'b1
    } kb_mode_e;
endpackage

// File: rtl/kb_msb_isolate.sv
// Keeps only the highest set bit of the input. A zero input gives zero.
module kb_msb_isolate #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_top
);
    logic [WIDTH-1:0] any_above;

    assign any_above[WIDTH-1] = 1'b0;
    for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_chain
        assign any_above[i] = any_above[i+1] | vec_in[i+1];
    end

    assign vec_top = vec_in & ~any_above;
endmodule

// File: rtl/kb_raise_core.sv
// Combinational raise-to-consistent rule for one bound.
module kb_raise_core #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] bound,
    input  logic [WIDTH-1:0] may_zero,
    input  logic [WIDTH-1:0] may_one,
    output logic [WIDTH-1:0] result,
    output logic             no_fit
);
    logic [WIDTH-1:0] mismatch;
    logic [WIDTH-1:0] cand;
    logic [WIDTH-1:0] top_miss;
    logic [WIDTH-1:0] pick;
    logic [WIDTH-1:0] keep_mask;
    logic [WIDTH-1:0] raised;
    logic             any_miss;

    kb_msb_isolate #(.WIDTH(WIDTH)) u_top (
        .vec_in (mismatch),
        .vec_top(top_miss)
    );

    always_comb begin
        // a clear bit that must be one, or a set bit that cannot be one
        mismatch  = (~bound & ~may_zero) | (bound & ~may_one);
        any_miss  = |mismatch;
        cand      = ~bound & may_one;
        // lowest candidate at or above the top mismatch
        pick      = cand & (~cand + top_miss);
        keep_mask = ~pick + {{(WIDTH-1){1'b0}}, 1'b1};
        raised    = (bound & keep_mask) | pick | ~may_zero;
        no_fit    = any_miss && (pick == '0);
        result    = (any_miss && !no_fit) ? raised : bound;
    end
endmodule

// File: rtl/kb_bound_sharpener.sv
module kb_bound_sharpener #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_upper,
    input  logic [WIDTH-1:0] in_bound,
    input  logic [WIDTH-1:0] in_may_zero,
    input  logic [WIDTH-1:0] in_may_one,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_bound,
    output logic             out_infeasible
);
    import kb_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] bnd;
        logic             inf;
    } kb_state_t;

    kb_state_t        st_d, st_q;
    kb_mode_e         mode;
    logic [WIDTH-1:0] core_bound, core_zero, core_one, core_res;
    logic             core_nofit;

    assign mode = kb_mode_e'(in_upper);

    kb_raise_core #(.WIDTH(WIDTH)) u_core (
        .bound   (core_bound),
        .may_zero(core_zero),
        .may_one (core_one),
        .result  (core_res),
        .no_fit  (core_nofit)
    );

    always_comb begin
        // lower mode: complement the bound and swap the masks
        if (mode == KB_LOWER_HIGH) begin
            core_bound = ~in_bound;
            core_zero  = in_may_one;
            core_one   = in_may_zero;
        end else begin
            core_bound = in_bound;
            core_zero  = in_may_zero;
            core_one   = in_may_one;
        end
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.bnd = (mode == KB_LOWER_HIGH) ? ~core_res : core_res;
            st_d.inf = core_nofit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.vld;
    assign out_bound      = st_q.bnd;
    assign out_infeasible = st_q.inf;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_raise_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_upper) |=> (out_bound >= $past(in_bound)));
    p_lower_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_upper) |=> (out_bound <= $past(in_bound)));
    p_nofit_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_infeasible) |-> (out_bound == $past(in_bound)));
    p_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((in_may_zero | in_may_one) == '1)) |=>
        (out_infeasible || (((out_bound & ~$past(in_may_one)) == '0) &&
                            ((~out_bound & ~$past(in_may_zero)) == '0))));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_bound) && $stable(out_infeasible)));
endmodule

// File: tb/sim_kb_bound_sharpener.sv
module sim_kb_bound_sharpener;
    localparam int W = 8;
    localparam int N = 1 << W;

    typedef struct {
        logic [W-1:0] bnd;
        logic         inf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_upper = 1'b0;
    logic [W-1:0] in_bound = '0;
    logic [W-1:0] in_may_zero = '1;
    logic [W-1:0] in_may_one = '1;
    logic         out_valid;
    logic [W-1:0] out_bound;
    logic         out_infeasible;

    exp_t         sb[$];
    int           n_checks = 0;
    int           n_errors = 0;
    logic [W-1:0] last_bnd = '0;
    logic         last_inf = 1'b0;

    always #10 clk = ~clk;

    kb_bound_sharpener #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_upper(in_upper),
        .in_bound(in_bound), .in_may_zero(in_may_zero), .in_may_one(in_may_one),
        .out_valid(out_valid), .out_bound(out_bound), .out_infeasible(out_infeasible)
    );

    function automatic bit fits(int v, logic [W-1:0] mz, logic [W-1:0] mo);
        logic [W-1:0] x;
        x = v[W-1:0];
        return ((x & ~mo) == '0) && ((~x & ~mz) == '0);
    endfunction

    task automatic push(input logic up, input logic [W-1:0] b,
                        input logic [W-1:0] mz, input logic [W-1:0] mo, input string tag);
        exp_t e;
        int   found;
        found = -1;
        if (!up) begin
            for (int v = 0; v < N; v++)
                if (found < 0 && v >= int'(b) && fits(v, mz, mo)) found = v;
        end else begin
            for (int v = N - 1; v >= 0; v--)
                if (found < 0 && v <= int'(b) && fits(v, mz, mo)) found = v;
        end
        e.inf = (found < 0);
        e.bnd = e.inf ? b : found[W-1:0];
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b1; in_upper = up; in_bound = b;
        in_may_zero = mz; in_may_one = mo;
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_bound = in_bound + 8'd37;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                exp_t e;
                n_checks++;
                if (sb.size() == 0) begin
                    n_errors++;
                    $display("FAIL R1: unexpected result %0h, expected no result", out_bound);
                end else begin
                    e = sb.pop_front();
                    if (out_bound !== e.bnd || out_infeasible !== e.inf) begin
                        n_errors++;
                        $display("FAIL %s: got bound %0h inf %0b, expected bound %0h inf %0b",
                                 e.tag, out_bound, out_infeasible, e.bnd, e.inf);
                    end
                end
                last_bnd = out_bound;
                last_inf = out_infeasible;
            end else if (!in_valid) begin
                // R8: idle cycles keep the last result
                n_checks++;
                if (out_bound !== last_bnd || out_infeasible !== last_inf) begin
                    n_errors++;
                    $display("FAIL R8: got %0h/%0b, expected %0h/%0b",
                             out_bound, out_infeasible, last_bnd, last_inf);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [W-1:0] kn, kv, mz, mo;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_bound !== '0 || out_infeasible !== 1'b0) begin
            n_errors++;
            $display("FAIL R2: got %0b/%0h/%0b, expected 0/0/0",
                     out_valid, out_bound, out_infeasible);
        end
        rst_n = 1'b1;
        idle(2);
        // R4: bound 5 with bit 0 known zero gives 6
        push(1'b0, 8'd5, 8'hFF, 8'hFE, "R4");
        // R3: no constraints, both modes pass through
        push(1'b0, 8'h9C, 8'hFF, 8'hFF, "R3");
        push(1'b1, 8'h9C, 8'hFF, 8'hFF, "R3");
        // R5: upper bound 6 with bit 0 known one gives 5
        push(1'b1, 8'd6, 8'hFE, 8'hFF, "R5");
        // R6: raise 0xFF with bit 0 known zero has no fit
        push(1'b0, 8'hFF, 8'hFF, 8'hFE, "R6");
        // R6: lower 0x00 with bit 7 known one has no fit
        push(1'b1, 8'h00, 8'h7F, 8'hFF, "R6");
        idle(3);
        // R4/R5/R7: random consistent masks, both modes
        for (int k = 0; k < 600; k++) begin
            kn = $urandom; kv = $urandom;
            mz = ~(kn & kv);
            mo = ~(kn & ~kv);
            push(k[0], 8'($urandom), mz, mo, k[0] ? "R5" : "R4");
            if (k % 50 == 49) idle(2);
        end
        idle(3);
        // R1: back to back done above; check no stray results
        n_checks++;
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule